// File: doc/BRIEF.md
# Mirrored-Output GPIO Bank

This block is a bank of up to 32 general-purpose pins behind a simple word-addressed register port. Each pin owns one 32-bit control word that sets power gating, direction, push-pull or open-drain drive, pull resistors, output polarity, input-pad disable, the pin's output level and its interrupt detection mode. The bank also exposes a parallel input word, a parallel output word, a sticky interrupt status word and an interrupt enable word. Bit n of every bank-wide word belongs to pin n.

A pin's output level is stored once and appears in two places: in bit 8 of its control word and in bit n of the parallel output word. A per-pin write-path select bit decides which of the two views accepts writes. The other view is read-only, and writes to it are dropped. Firmware can therefore program a pin in full through its control word and then hand the output level over to the parallel word for fast bank-wide updates.

Pad inputs are gated by the input-pad enable and pass through a two-flop synchroniser. A per-pin detector then flags levels or edges into a sticky status bit. The bank interrupt line is raised when any status bit is set and its enable bit is also set.

Top module: `gpio_mirror_bank`

## Requirements
- R1: After reset every control word reads 0, and the parallel output, status and enable words read 0. `irq` is 0 and no `pad_oe` bit is set.
- R2: The control word of pin n is at byte address 4·n. The parallel input word is at 0x80, the parallel output word at 0x84, the status word at 0x88 and the enable word at 0x8C. Writing one control word leaves the other pins' words unchanged.
- R3: Control-word bit 8 of pin n and bit n of the parallel output word always read the same value.
- R4: When the write-path select (control bit 9) is 0, a control-word write updates bit 8 and a parallel output write to that pin's bit is ignored.
- R5: When the select is 1, a parallel output write updates the level and the bit-8 value of a control-word write is ignored. The select value held before a write decides which path wins.
- R6: Power field bits [1:0] = 2'b10 means off; any other value means powered. A powered output pin (bit 2 = 1) drives `pad_out` = level XOR polarity (bit 6) with `pad_oe` = 1 in push-pull mode. With open drain (bit 3 = 1) it sets `pad_oe` only when that driven value is 0, and `pad_out` is then 0. An off pin never drives.
- R7: Bit 4 drives `pad_pu` and bit 5 drives `pad_pd`. Setting both selects keeper mode, with both outputs asserted. An off pin asserts neither.
- R8: The read-only input bit (control bit 10) and bit n of the parallel input word show the pad value two clock edges after it changes, while the input is enabled. They read 0 when the pin is off or when input-pad disable (bit 7) is set.
- R9: Detection field bits [14:12] select the mode: 0 disabled, 1 high level, 2 low level, 3 rising edge, 4 falling edge, 5 both edges. Codes 6 and 7 act as disabled.
- R10: No detection occurs while the pin is off or its input pad is disabled, even when the pin is an output and the pad toggles.
- R11: After a change of detection mode or input enable, the detector stays quiet for SETTLE cycles. It never reports an edge caused by the change itself.
- R12: Status bits are sticky. Writing 1 to a bit of the status word clears it, and writing 0 has no effect. A level condition that still holds sets the bit again.
- R13: `irq` is 1 exactly when some status bit is set and its enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pull-up enables |
| pad_pd | output | NPINS | Pull-down enables |
| irq | output | 1 | Bank interrupt |

## Verification
The bench writes both output views under each select setting and checks that only one path takes effect. It also checks that the select held before a write, not the new one, is what decides. A design that let both views write, or that let the new select act early, would show a level change after the blocked write. The bench enables the input of a pin whose pad is already high while a rising-edge mode is selected. It also changes modes on a steady pad. A detector without the settle window would report a false edge in these cases. Finally, the bench toggles the pad of an output pin whose input is disabled, and steps through every detection code with clears in between. This catches detectors that ignore the gate or that treat the codes wrongly.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
  typedef enum logic [2:0] {
    DET_OFF  = 3'd0,
    DET_HI   = 3'd1,
    DET_LO   = 3'd2,
    DET_RISE = 3'd3,
    DET_FALL = 3'd4,
    DET_BOTH = 3'd5
  } det_mode_e;

  localparam logic [1:0] PWR_OFF = 2'b10;

  localparam int B_DIR   = 2;
  localparam int B_OD    = 3;
  localparam int B_PU    = 4;
  localparam int B_PD    = 5;
  localparam int B_POL   = 6;
  localparam int B_INDIS = 7;
  localparam int B_LVL   = 8;
  localparam int B_SEL   = 9;
  localparam int B_INVAL = 10;
  localparam int B_DET   = 12;

  localparam int W_PAR_IN  = 32;
  localparam int W_PAR_OUT = 33;
  localparam int W_STAT    = 34;
  localparam int W_EN      = 35;
endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_mb_pin_cfg.sv
module gpio_mb_pin_cfg
  import gpio_mb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] wdata,
  input  logic        par_we,
  input  logic        par_bit,
  input  logic        in_sync,
  output logic [31:0] ctrl_rd,
  output logic        lvl,
  output logic        sel,
  output logic        powered,
  output logic        in_en,
  output logic        in_val,
  output logic [2:0]  det_mode,
  output logic        pad_oe,
  output logic        pad_out,
  output logic        pad_pu,
  output logic        pad_pd
);
  logic [1:0] pwr_q, pwr_d;
  logic       dir_q, dir_d, od_q, od_d, pu_q, pu_d, pd_q, pd_d;
  logic       pol_q, pol_d, indis_q, indis_d, lvl_q, lvl_d, sel_q, sel_d;
  logic [2:0] det_q, det_d;
  logic       cfg_en, lvl_en;
  logic       drive;

  always_comb begin
    cfg_en  = ctrl_we;
    pwr_d   = wdata[1:0];
    dir_d   = wdata[B_DIR];
    od_d    = wdata[B_OD];
    pu_d    = wdata[B_PU];
    pd_d    = wdata[B_PD];
    pol_d   = wdata[B_POL];
    indis_d = wdata[B_INDIS];
    sel_d   = wdata[B_SEL];
    det_d   = wdata[B_DET+2:B_DET];
    // the select held before this cycle picks the writable view
    lvl_en  = 1'b0;
    lvl_d   = lvl_q;
    if (ctrl_we && !sel_q) begin
      lvl_en = 1'b1;
      lvl_d  = wdata[B_LVL];
    end else if (par_we && sel_q) begin
      lvl_en = 1'b1;
      lvl_d  = par_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 2'b00;
      dir_q   <= 1'b0;
      od_q    <= 1'b0;
      pu_q    <= 1'b0;
      pd_q    <= 1'b0;
      pol_q   <= 1'b0;
      indis_q <= 1'b0;
      sel_q   <= 1'b0;
      det_q   <= DET_OFF;
    end else if (cfg_en) begin
      pwr_q   <= pwr_d;
      dir_q   <= dir_d;
      od_q    <= od_d;
      pu_q    <= pu_d;
      pd_q    <= pd_d;
      pol_q   <= pol_d;
      indis_q <= indis_d;
      sel_q   <= sel_d;
      det_q   <= det_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign powered  = (pwr_q != PWR_OFF);
  assign in_en    = powered && !indis_q;
  assign in_val   = in_sync && in_en;
  assign lvl      = lvl_q;
  assign sel      = sel_q;
  assign det_mode = det_q;
  assign drive    = lvl_q ^ pol_q;
  assign pad_oe   = powered && dir_q && (!od_q || !drive);
  assign pad_out  = od_q ? 1'b0 : drive;
  assign pad_pu   = powered && pu_q;
  assign pad_pd   = powered && pd_q;

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[1:0]             = pwr_q;
    ctrl_rd[B_DIR]           = dir_q;
    ctrl_rd[B_OD]            = od_q;
    ctrl_rd[B_PU]            = pu_q;
    ctrl_rd[B_PD]            = pd_q;
    ctrl_rd[B_POL]           = pol_q;
    ctrl_rd[B_INDIS]         = indis_q;
    ctrl_rd[B_LVL]           = lvl_q;
    ctrl_rd[B_SEL]           = sel_q;
    ctrl_rd[B_INVAL]         = in_val;
    ctrl_rd[B_DET+2:B_DET]   = det_q;
  end
endmodule

// File: rtl/gpio_mb_detect.sv
module gpio_mb_detect
  import gpio_mb_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_en,
  input  logic [2:0] mode,
  input  logic       s,
  output logic       hit
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [3:0]    cfg, cfg_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q;
  logic          quiet, cond;

  assign cfg   = {in_en, mode};
  assign quiet = (cfg != cfg_q) || (cnt_q != '0);

  always_comb begin
    if (cfg != cfg_q)      cnt_d = CW'(SETTLE);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_comb begin
    case (mode)
      DET_HI:   cond = s;
      DET_LO:   cond = !s;
      DET_RISE: cond = s && !prev_q;
      DET_FALL: cond = !s && prev_q;
      DET_BOTH: cond = s ^ prev_q;
      default:  cond = 1'b0;
    endcase
  end

  assign hit = cond && in_en && !quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cfg_q  <= cfg;
      cnt_q  <= cnt_d;
      prev_q <= s;
    end
  end
endmodule

// File: rtl/gpio_mirror_bank.sv
module gpio_mirror_bank
  import gpio_mb_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int SETTLE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [NPINS-1:0]  lvl_vec, sel_vec, off_vec, in_en_vec, in_val_vec, hit_vec;
  logic [NPINS-1:0]  sync_vec;
  logic [NPINS-1:0]  status_q, status_d, irq_en_q, clr_vec;
  logic [31:0]       ctrl_rd [NPINS];
  logic              par_we, stat_we, en_we;

  assign word    = reg_addr[ADDR_W-1:2];
  assign par_we  = reg_we && (word == WORD_W'(W_PAR_OUT));
  assign stat_we = reg_we && (word == WORD_W'(W_STAT));
  assign en_we   = reg_we && (word == WORD_W'(W_EN));

  gpio_mb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in & in_en_vec), .q(sync_vec)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic       pwr_on;
    logic [2:0] mode;

    gpio_mb_pin_cfg u_cfg (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(reg_we && (word == WORD_W'(n))),
      .wdata(reg_wdata),
      .par_we(par_we), .par_bit(reg_wdata[n]),
      .in_sync(sync_vec[n]),
      .ctrl_rd(ctrl_rd[n]),
      .lvl(lvl_vec[n]), .sel(sel_vec[n]),
      .powered(pwr_on), .in_en(in_en_vec[n]), .in_val(in_val_vec[n]),
      .det_mode(mode),
      .pad_oe(pad_oe[n]), .pad_out(pad_out[n]),
      .pad_pu(pad_pu[n]), .pad_pd(pad_pd[n])
    );

    assign off_vec[n] = !pwr_on;

    gpio_mb_detect #(.SETTLE(SETTLE)) u_det (
      .clk(clk), .rst_n(rst_n), .in_en(in_en_vec[n]), .mode(mode),
      .s(sync_vec[n]), .hit(hit_vec[n])
    );
  end

  assign clr_vec  = stat_we ? reg_wdata[NPINS-1:0] : '0;
  assign status_d = (status_q & ~clr_vec) | hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_en_q <= '0;
    else if (en_we) irq_en_q <= reg_wdata[NPINS-1:0];
  end

  assign irq = |(status_q & irq_en_q);

  always_comb begin
    reg_rdata = '0;
    if (int'(word) < NPINS)                   reg_rdata = ctrl_rd[int'(word)];
    else if (word == WORD_W'(W_PAR_IN))       reg_rdata = 32'(in_val_vec);
    else if (word == WORD_W'(W_PAR_OUT))      reg_rdata = 32'(lvl_vec);
    else if (word == WORD_W'(W_STAT))         reg_rdata = 32'(status_q);
    else if (word == WORD_W'(W_EN))           reg_rdata = 32'(irq_en_q);
  end
endmodule

// File: rtl/gpio_mirror_bank_chk.sv
module gpio_mirror_bank_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              irq,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  irq_en_q,
  input logic [NPINS-1:0]  off_vec,
  input logic [NPINS-1:0]  in_en_vec,
  input logic [NPINS-1:0]  sel_vec,
  input logic [NPINS-1:0]  lvl_vec
);
  logic par_wr, stat_wr, ctrl_wr;
  assign par_wr  = reg_we && (reg_addr == ADDR_W'(8'h84));
  assign stat_wr = reg_we && (reg_addr == ADDR_W'(8'h88));
  assign ctrl_wr = reg_we && (reg_addr < ADDR_W'(8'h80));

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & off_vec) == '0) else $error("off pin drives"); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)))
    else $error("status dropped without clear"); // R12

  AST_NO_DET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(in_en_vec)) == '0))
    else $error("detection while input blocked"); // R10

  AST_PAR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_wr && (sel_vec == '0)) |=> $stable(lvl_vec))
    else $error("parallel write passed with select 0"); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irq_en_q != '0) && (status_q != '0)))
    else $error("irq without enabled status"); // R13
endmodule

bind gpio_mirror_bank gpio_mirror_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .irq(irq),
  .pad_oe(pad_oe), .status_q(status_q), .irq_en_q(irq_en_q), .off_vec(off_vec),
  .in_en_vec(in_en_vec), .sel_vec(sel_vec), .lvl_vec(lvl_vec)
);

// File: tb/gpio_mirror_bank_test.sv
module gpio_mirror_bank_test;
  localparam int NPINS = 32;
  localparam int SETTLE = 3;
  localparam logic [7:0] A_PIN = 8'h80, A_POUT = 8'h84, A_STAT = 8'h88, A_EN = 8'h8C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  gpio_mirror_bank #(.NPINS(NPINS), .ADDR_W(8), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic t_reset;
    rd(8'h00, d); chk("R1 ctrl0", d, 32'h0);
    rd(8'h7C, d); chk("R1 ctrl31", d, 32'h0);
    rd(A_POUT, d); chk("R1 parout", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_EN, d);   chk("R1 enable", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_address;
    wr(8'h7C, 32'h0000_5000);
    rd(8'h7C, d); chk("R2 pin31 word", d, 32'h0000_5000);
    rd(8'h78, d); chk("R2 pin30 untouched", d, 32'h0);
    wr(8'h7C, 32'h0);
  endtask

  task automatic t_sel0;
    wr(8'h00, 32'h104);
    rd(A_POUT, d); chk("R3 parout mirrors ctrl", d & 32'h1, 32'h1);
    chk("R6 push-pull oe", {31'b0, pad_oe[0]}, 32'h1);
    chk("R6 push-pull out", {31'b0, pad_out[0]}, 32'h1);
    wr(A_POUT, 32'h0);
    rd(8'h00, d); chk("R4 parout write ignored", d & 32'h100, 32'h100);
    chk("R4 pad level kept", {31'b0, pad_out[0]}, 32'h1);
  endtask

  task automatic t_sel1;
    wr(8'h00, 32'h304);
    rd(8'h00, d); chk("R5 old select lets ctrl level in", d & 32'h300, 32'h300);
    wr(8'h00, 32'h204);
    rd(8'h00, d); chk("R5 ctrl level ignored", d & 32'h100, 32'h100);
    wr(A_POUT, 32'h0);
    rd(8'h00, d); chk("R5 parout write lands", d & 32'h100, 32'h0);
    rd(A_POUT, d); chk("R3 mirror after parout write", d & 32'h1, 32'h0);
    chk("R5 pad follows", {31'b0, pad_out[0]}, 32'h0);
  endtask

  task automatic t_drive;
    wr(8'h04, 32'h10C);
    chk("R6 open drain high released", {31'b0, pad_oe[1]}, 32'h0);
    wr(8'h04, 32'h00C);
    chk("R6 open drain low oe", {31'b0, pad_oe[1]}, 32'h1);
    chk("R6 open drain low out", {31'b0, pad_out[1]}, 32'h0);
    wr(8'h08, 32'h044);
    chk("R6 polarity inverts", {31'b0, pad_out[2]}, 32'h1);
    wr(8'h0C, 32'h106);
    chk("R6 off pin not driven", {31'b0, pad_oe[3]}, 32'h0);
  endtask

  task automatic t_pull;
    wr(8'h10, 32'h10);
    chk("R7 pull-up only", {30'b0, pad_pd[4], pad_pu[4]}, 32'h1);
    wr(8'h10, 32'h30);
    chk("R7 keeper both", {30'b0, pad_pd[4], pad_pu[4]}, 32'h3);
    wr(8'h10, 32'h32);
    chk("R7 off no pulls", {30'b0, pad_pd[4], pad_pu[4]}, 32'h0);
  endtask

  task automatic t_input;
    pad_in[5] = 1'b1;
    cyc(3);
    rd(A_PIN, d);  chk("R8 parin follows pad", (d >> 5) & 1, 32'h1);
    rd(8'h14, d);  chk("R8 ctrl input bit", (d >> 10) & 1, 32'h1);
    wr(8'h14, 32'h80);
    rd(A_PIN, d);  chk("R8 pad disabled reads 0", (d >> 5) & 1, 32'h0);
    wr(8'h14, 32'h2);
    cyc(3);
    rd(A_PIN, d);  chk("R8 off reads 0", (d >> 5) & 1, 32'h0);
    @(negedge clk); pad_in[6] = 1'b1;
    @(negedge clk);
    rd(A_PIN, d);  chk("R8 one edge not yet", (d >> 6) & 1, 32'h0);
    @(negedge clk);
    rd(A_PIN, d);  chk("R8 two edges visible", (d >> 6) & 1, 32'h1);
  endtask

  task automatic clear_st;
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_detect;
    pad_in[7] = 1'b0;
    wr(8'h1C, 32'h3000); cyc(SETTLE + 3); clear_st();
    pad_in[7] = 1'b1; cyc(4);
    rd(A_STAT, d); chk("R9 rising sets", (d >> 7) & 1, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R12 write 0 keeps", (d >> 7) & 1, 32'h1);
    wr(A_STAT, 32'h80);
    rd(A_STAT, d); chk("R12 write 1 clears", (d >> 7) & 1, 32'h0);
    cyc(4);
    rd(A_STAT, d); chk("R9 steady high no rise", (d >> 7) & 1, 32'h0);
    wr(8'h1C, 32'h4000); cyc(SETTLE + 3); clear_st();
    pad_in[7] = 1'b0; cyc(4);
    rd(A_STAT, d); chk("R9 falling sets", (d >> 7) & 1, 32'h1);
    wr(8'h1C, 32'h5000); cyc(SETTLE + 3); clear_st();
    pad_in[7] = 1'b1; cyc(4);
    rd(A_STAT, d); chk("R9 both on rise", (d >> 7) & 1, 32'h1);
    clear_st(); pad_in[7] = 1'b0; cyc(4);
    rd(A_STAT, d); chk("R9 both on fall", (d >> 7) & 1, 32'h1);
    wr(8'h1C, 32'h2000); cyc(SETTLE + 3); clear_st(); cyc(1);
    rd(A_STAT, d); chk("R12 low level resets after clear", (d >> 7) & 1, 32'h1);
    pad_in[7] = 1'b1;
    wr(8'h1C, 32'h1000); cyc(SETTLE + 3); clear_st(); cyc(1);
    rd(A_STAT, d); chk("R9 high level", (d >> 7) & 1, 32'h1);
    wr(8'h1C, 32'h7000); cyc(SETTLE + 3); clear_st();
    pad_in[7] = 1'b0; cyc(3); pad_in[7] = 1'b1; cyc(3);
    rd(A_STAT, d); chk("R9 code 7 disabled", (d >> 7) & 1, 32'h0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_settle;
    pad_in[8] = 1'b1;
    wr(8'h20, 32'h3080); cyc(SETTLE + 3); clear_st();
    wr(8'h20, 32'h3000); cyc(SETTLE + 4);
    rd(A_STAT, d); chk("R11 no edge from input enable", (d >> 8) & 1, 32'h0);
    wr(8'h20, 32'h5000); cyc(SETTLE + 4);
    rd(A_STAT, d); chk("R11 no edge from mode change", (d >> 8) & 1, 32'h0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_blocked;
    wr(8'h24, 32'h5084); cyc(SETTLE + 3); clear_st();
    pad_in[9] = 1'b1; cyc(3); pad_in[9] = 1'b0; cyc(3);
    rd(A_STAT, d); chk("R10 output pin pad disabled", (d >> 9) & 1, 32'h0);
    wr(8'h24, 32'h5002); cyc(SETTLE + 3);
    pad_in[9] = 1'b1; cyc(3); pad_in[9] = 1'b0; cyc(3);
    rd(A_STAT, d); chk("R10 off pin", (d >> 9) & 1, 32'h0);
    wr(8'h24, 32'h0);
  endtask

  task automatic t_irq;
    pad_in[7] = 1'b0;
    wr(8'h1C, 32'h3000); cyc(SETTLE + 3); clear_st();
    pad_in[7] = 1'b1; cyc(4);
    chk("R13 masked", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0400);
    chk("R13 other bit enabled", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0080);
    chk("R13 enabled fires", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h80);
    chk("R13 cleared drops", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_address();
    t_sel0();
    t_sel1();
    t_drive();
    t_pull();
    t_input();
    t_detect();
    t_settle();
    t_blocked();
    t_irq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule